// File: doc/BRIEF.md
# Truth-Table Logic Cell

This block models one programmable logic cell built from small truth-table memories. Two 4-input generators (named F and G) each look up a 16-entry, 1-bit table. A third, 3-input generator (H) looks up an 8-entry table indexed by the F output, the G output and one spare cell input. With this arrangement a single cell covers any 5-input function, or wider functions such as 9-bit parity. Two flip-flops can register any generator output under a shared clock enable.

Before use, every table bit and mode bit is shifted into the cell serially, one bit per clock when the load strobe is high. Until the 45th bit has arrived, every output of the cell reads 0. After configuration, the cell either evaluates logic or, when its mode bit asks for it, uses the 32 bits of F and G storage as a small user RAM. That RAM has a synchronous write and an asynchronous read. The logic outputs keep evaluating from the same storage in RAM mode.

Top module: `lut_cell`

## Requirements
- R1: The load stream is 45 bits, accepted on rising `clk` edges where `load_en` is high, most significant bit first, in this order: F table bit 15..0, G table bit 15..0, H table bit 7..0, X source (2 bits, MSB first), Y source (2 bits, MSB first), RAM-mode flag. `cfg_done` goes high at the edge that accepts the 45th bit. Bits offered after that are ignored until `load_restart`.
- R2: While `cfg_done` is low, `f_out`, `g_out`, `h_out` and `ram_rdata` are 0, and the flip-flops load 0.
- R3: `f_out` is F table bit number `f_in` and `g_out` is G table bit number `g_in`, combinationally.
- R4: `h_out` is H table bit number {`h_in`, `g_out`, `f_out`}, with `h_in` as the index MSB and `f_out` as the LSB.
- R5: A cell loaded with F = G = 16'h6996 and H = 8'h96 produces on `h_out` the parity of the nine bits `f_in`, `g_in` and `h_in`.
- R6: Source code 0 routes F, code 1 routes G, and codes 2 and 3 route H into a flip-flop. `x_q` and `y_q` update on the rising edge when `ce` is high.
- R7: With `ce` low and `rst` low, `x_q` and `y_q` hold their values across a clock edge.
- R8: `rst` clears `x_q` and `y_q` to 0 at the next edge, taking priority over `ce`, and leaves all table and mode contents unchanged.
- R9: In RAM mode, with `cfg_done` high, a rising edge with `ram_we` high writes `ram_wdata` into the F table (`ram_addr[4]`=0) or the G table (`ram_addr[4]`=1) at bit `ram_addr[3:0]`. `ram_rdata` shows the addressed bit asynchronously. In logic mode, `ram_we` has no effect.
- R10: `load_restart` at an edge clears `cfg_done`, so the outputs return to 0, and starts a fresh 45-bit load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading, RAM writes and flip-flops |
| rst | input | 1 | Synchronous active-high flip-flop clear |
| load_restart | input | 1 | Restarts the configuration load |
| load_en | input | 1 | Accept one configuration bit this edge |
| load_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | All 45 configuration bits received |
| f_in | input | 4 | F generator index |
| g_in | input | 4 | G generator index |
| h_in | input | 1 | Spare input to H generator |
| ce | input | 1 | Shared flip-flop clock enable |
| ram_we | input | 1 | User RAM write enable |
| ram_addr | input | 5 | User RAM address; bit 4 picks G over F |
| ram_wdata | input | 1 | User RAM write data |
| f_out | output | 1 | F generator output |
| g_out | output | 1 | G generator output |
| h_out | output | 1 | H generator output |
| x_q | output | 1 | First registered output |
| y_q | output | 1 | Second registered output |
| ram_rdata | output | 1 | Asynchronous RAM read data |

## Verification
The assertions assume that `rst` and `load_restart` are both held high in the first cycle, so the bit counter and flip-flops have known values, and they are disabled whenever either is asserted. The table-hold and RAM-write checks assume that no load is in progress once `cfg_done` is high. The bench only raises `load_en` during a fresh load of exactly 45 bits, plus one deliberate burst of extra bits after completion. All inputs change at the falling clock edge, never at the rising edge, so every edge samples stable values.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int unsigned LUT4_BITS = 16;
    localparam int unsigned LUT3_BITS = 8;
    localparam int unsigned SRC_BITS  = 2;
    localparam int unsigned MODE_BITS = 2 * SRC_BITS + 1;
    localparam int unsigned CFG_BITS  = 2 * LUT4_BITS + LUT3_BITS + MODE_BITS;
    localparam int unsigned ADDR_BITS = $clog2(2 * LUT4_BITS);

    typedef enum logic [SRC_BITS-1:0] {
        SRC_F  = 2'd0,
        SRC_G  = 2'd1,
        SRC_H  = 2'd2,
        SRC_H2 = 2'd3
    } ff_src_e;

    // Field order matches the serial stream (first bit lands in the MSB).
    typedef struct packed {
        logic [LUT4_BITS-1:0] f_tab;
        logic [LUT4_BITS-1:0] g_tab;
        logic [LUT3_BITS-1:0] h_tab;
        ff_src_e              x_src;
        ff_src_e              y_src;
        logic                 ram_mode;
    } cell_cfg_t;

    localparam int unsigned H_LSB = MODE_BITS;
    localparam int unsigned G_LSB = H_LSB + LUT3_BITS;
    localparam int unsigned F_LSB = G_LSB + LUT4_BITS;

    function automatic logic ram_bit(cell_cfg_t c, logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-1] ? c.g_tab[a[ADDR_BITS-2:0]] : c.f_tab[a[ADDR_BITS-2:0]];
    endfunction

endpackage

// File: rtl/lut_cell_store.sv
module lut_cell_store
    import lut_cell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_restart,
    input  logic                 load_en,
    input  logic                 load_bit,
    input  logic                 ram_we,
    input  logic [ADDR_BITS-1:0] ram_addr,
    input  logic                 ram_wdata,
    output cell_cfg_t            cfg,
    output logic                 done
);
    localparam int unsigned CNT_W = $clog2(CFG_BITS + 1);

    logic [CFG_BITS-1:0] bits_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                wr_hit;

    assign done   = (cnt_q == CNT_W'(CFG_BITS));
    assign cfg    = cell_cfg_t'(bits_q);
    assign wr_hit = done && cfg.ram_mode && ram_we;

    always_ff @(posedge clk) begin
        if (load_restart) begin
            cnt_q <= '0;
        end else if (load_en && !done) begin
            bits_q <= {bits_q[CFG_BITS-2:0], load_bit};
            cnt_q  <= cnt_q + 1'b1;
        end else if (wr_hit) begin
            if (ram_addr[ADDR_BITS-1])
                bits_q[G_LSB + int'(ram_addr[ADDR_BITS-2:0])] <= ram_wdata;
            else
                bits_q[F_LSB + int'(ram_addr[ADDR_BITS-2:0])] <= ram_wdata;
        end
    end

    // R1: once complete, the load stays complete until restarted
    p_done_sticky_r1: assert property (@(posedge clk) disable iff (rst || load_restart)
        done |=> done);

    // R9: with no write and load finished, tables and modes are frozen
    p_tables_hold_r9: assert property (@(posedge clk) disable iff (rst || load_restart)
        (done && !wr_hit) |=> $stable(bits_q));

    // R9: a RAM write is visible at its address after the edge
    p_ram_write_r9: assert property (@(posedge clk) disable iff (rst || load_restart)
        wr_hit |=> (ram_bit(cfg, $past(ram_addr)) == $past(ram_wdata)));

    always_comb begin
        if (!rst && !load_restart) p_cnt_bound_r1: assert (cnt_q <= CNT_W'(CFG_BITS));
    end

endmodule

// File: rtl/lut_cell_eval.sv
module lut_cell_eval
    import lut_cell_pkg::*;
(
    input  cell_cfg_t            cfg,
    input  logic                 done,
    input  logic [3:0]           f_in,
    input  logic [3:0]           g_in,
    input  logic                 h_in,
    input  logic [ADDR_BITS-1:0] ram_addr,
    output logic                 f_out,
    output logic                 g_out,
    output logic                 h_out,
    output logic                 ram_rdata
);
    logic f_raw, g_raw, h_raw;

    assign f_raw = cfg.f_tab[f_in];
    assign g_raw = cfg.g_tab[g_in];
    assign h_raw = cfg.h_tab[{h_in, g_raw, f_raw}];

    assign f_out     = done & f_raw;
    assign g_out     = done & g_raw;
    assign h_out     = done & h_raw;
    assign ram_rdata = done & ram_bit(cfg, ram_addr);
endmodule

// File: rtl/lut_cell_regs.sv
module lut_cell_regs
    import lut_cell_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce,
    input  ff_src_e x_src,
    input  ff_src_e y_src,
    input  logic    f_val,
    input  logic    g_val,
    input  logic    h_val,
    output logic    x_q,
    output logic    y_q
);
    localparam int unsigned NUM_FF = 2;

    logic [NUM_FF-1:0] q;

    for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
        ff_src_e sel;
        logic    d;
        logic    q_r;

        assign sel = (i == 0) ? x_src : y_src;

        always_comb begin
            case (sel)
                SRC_F:   d = f_val;
                SRC_G:   d = g_val;
                default: d = h_val;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)     q_r <= 1'b0;
            else if (ce) q_r <= d;
        end

        assign q[i] = q_r;
    end

    assign x_q = q[0];
    assign y_q = q[1];

    // R8: reset clears both flip-flops whatever the enable
    p_rst_clears_r8: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R7: no enable, no change
    p_ce_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ce && !$past(rst)) |=> $stable(q));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_restart,
    input  logic       load_en,
    input  logic       load_bit,
    output logic       cfg_done,
    input  logic [3:0] f_in,
    input  logic [3:0] g_in,
    input  logic       h_in,
    input  logic       ce,
    input  logic       ram_we,
    input  logic [4:0] ram_addr,
    input  logic       ram_wdata,
    output logic       f_out,
    output logic       g_out,
    output logic       h_out,
    output logic       x_q,
    output logic       y_q,
    output logic       ram_rdata
);
    cell_cfg_t cfg;
    logic      done;

    lut_cell_store u_store (
        .clk          (clk),
        .rst          (rst),
        .load_restart (load_restart),
        .load_en      (load_en),
        .load_bit     (load_bit),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .ram_wdata    (ram_wdata),
        .cfg          (cfg),
        .done         (done)
    );

    lut_cell_eval u_eval (
        .cfg       (cfg),
        .done      (done),
        .f_in      (f_in),
        .g_in      (g_in),
        .h_in      (h_in),
        .ram_addr  (ram_addr),
        .f_out     (f_out),
        .g_out     (g_out),
        .h_out     (h_out),
        .ram_rdata (ram_rdata)
    );

    lut_cell_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .x_src (cfg.x_src),
        .y_src (cfg.y_src),
        .f_val (f_out),
        .g_val (g_out),
        .h_val (h_out),
        .x_q   (x_q),
        .y_q   (y_q)
    );

    assign cfg_done = done;

    // R2: an unconfigured cell shows nothing on its outputs
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst || load_restart)
        !cfg_done |-> !(f_out || g_out || h_out || ram_rdata));
endmodule

// File: tb/lut_cell_test.sv
module lut_cell_test;
    logic       clk = 1'b0;
    logic       rst, load_restart, load_en, load_bit;
    logic       cfg_done;
    logic [3:0] f_in, g_in;
    logic       h_in, ce, ram_we, ram_wdata;
    logic [4:0] ram_addr;
    logic       f_out, g_out, h_out, x_q, y_q, ram_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lut_cell uut (
        .clk(clk), .rst(rst), .load_restart(load_restart), .load_en(load_en),
        .load_bit(load_bit), .cfg_done(cfg_done), .f_in(f_in), .g_in(g_in),
        .h_in(h_in), .ce(ce), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .f_out(f_out), .g_out(g_out), .h_out(h_out),
        .x_q(x_q), .y_q(y_q), .ram_rdata(ram_rdata)
    );

    typedef struct packed {
        logic [3:0] f;
        logic [3:0] g;
        logic       h;
        logic       ef;
        logic       eg;
        logic       eh;
    } vec_t;

    // 9-bit parity vectors: inputs and expected F, G, H outputs
    localparam vec_t VECS [8] = '{
        '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'b0001, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'b1010, 4'b0110, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'b0111, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'b1000, 4'b0010, 1'b1, 1'b1, 1'b1, 1'b1},
        '{4'b1110, 4'b1101, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'b0101, 4'b1011, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [44:0] mk(logic [15:0] ft, logic [15:0] gt, logic [7:0] ht,
                                       logic [1:0] xs, logic [1:0] ys, logic rm);
        return {ft, gt, ht, xs, ys, rm};
    endfunction

    task automatic shift_bits(logic [44:0] v, int n);
        for (int i = 44; i > 44 - n; i--) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_bit = v[i];
            @(posedge clk);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        load_restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_restart = 1'b0;
    endtask

    task automatic load(logic [44:0] v);
        restart();
        shift_bits(v, 45);
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; load_restart = 1'b1; load_en = 1'b0; load_bit = 1'b0;
        f_in = 4'hF; g_in = 4'hF; h_in = 1'b1; ce = 1'b1;
        ram_we = 1'b0; ram_addr = '0; ram_wdata = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0; load_restart = 1'b0;
        #2;
        // Reset state
        check("R2 done low after reset", cfg_done, 1'b0);
        check("R2 f_out before load", f_out, 1'b0);
        check("R2 h_out before load", h_out, 1'b0);
        check("R8 x_q after reset", x_q, 1'b0);
        check("R8 y_q after reset", y_q, 1'b0);

        // R1: partial load is not complete, 45th bit completes it
        begin
            logic [44:0] v = mk(16'h6996, 16'h6996, 8'h96, 2'd2, 2'd0, 1'b0);
            shift_bits(v, 44);
            #2;
            check("R1 done low after 44 bits", cfg_done, 1'b0);
            check("R2 ram_rdata before load", ram_rdata, 1'b0);
            @(negedge clk);
            load_en = 1'b1; load_bit = v[0];
            @(posedge clk);
            #5;
            check("R1 done high after 45 bits", cfg_done, 1'b1);
            @(negedge clk);
            load_en = 1'b0;
        end

        // R3 R4 R5 R6: vector table walk, X from H, Y from F
        foreach (VECS[k]) begin
            @(negedge clk);
            f_in = VECS[k].f; g_in = VECS[k].g; h_in = VECS[k].h;
            #2;
            check("R3 f_out lookup", f_out, VECS[k].ef);
            check("R3 g_out lookup", g_out, VECS[k].eg);
            check("R5 h_out nine-bit parity", h_out, VECS[k].eh);
            tick();
            check("R6 x_q takes H (code 2)", x_q, VECS[k].eh);
            check("R6 y_q takes F (code 0)", y_q, VECS[k].ef);
        end

        // R7: enable low holds the flops (last vector left x=1, y=0)
        @(negedge clk);
        ce = 1'b0; f_in = 4'b0001; g_in = 4'b0000; h_in = 1'b0;
        tick();
        check("R7 x_q held with ce low", x_q, 1'b1);
        check("R7 y_q held with ce low", y_q, 1'b0);

        // R8: reset beats enable, configuration survives
        @(negedge clk);
        ce = 1'b1; rst = 1'b1;
        tick();
        check("R8 x_q cleared", x_q, 1'b0);
        check("R8 y_q cleared", y_q, 1'b0);
        check("R8 f_out intact after reset", f_out, 1'b1);
        check("R8 cfg_done intact after reset", cfg_done, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // R9: write in logic mode has no effect (F bit 0 is 0)
        @(negedge clk);
        ram_we = 1'b1; ram_addr = 5'h00; ram_wdata = 1'b1;
        tick();
        @(negedge clk);
        ram_we = 1'b0; f_in = 4'h0;
        #2;
        check("R9 logic-mode write ignored", f_out, 1'b0);

        // R1: extra bits after completion are ignored
        shift_bits(45'h1FFF_FFFF_FFFF, 8);
        @(negedge clk);
        f_in = 4'h0; g_in = 4'h3; h_in = 1'b0;
        #2;
        check("R1 extra bits ignored (f)", f_out, 1'b0);
        check("R1 extra bits ignored (g)", g_out, 1'b0);

        // R1 R4: stream order, single-bit tables; X code 3, Y code 1
        load(mk(16'h0001, 16'h8000, 8'h40, 2'd3, 2'd1, 1'b0));
        f_in = 4'h0; g_in = 4'hF; h_in = 1'b1;
        #2;
        check("R1 F bit 0 placed last", f_out, 1'b1);
        check("R1 G bit 15 placed first", g_out, 1'b1);
        check("R4 H index {h,g,f}=3'b111 -> 0", h_out, 1'b0);
        @(negedge clk);
        f_in = 4'h1;
        #2;
        check("R3 f_out other index", f_out, 1'b0);
        check("R4 H index 3'b110 -> 1", h_out, 1'b1);
        tick();
        check("R6 x_q takes H (code 3)", x_q, 1'b1);
        check("R6 y_q takes G (code 1)", y_q, 1'b1);

        // R9: RAM mode writes and asynchronous reads
        load(mk(16'h0000, 16'h0000, 8'h00, 2'd0, 2'd0, 1'b1));
        ram_we = 1'b1; ram_addr = 5'h03; ram_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ram_addr = 5'h13;
        @(posedge clk);
        @(negedge clk);
        ram_we = 1'b0; ram_addr = 5'h03;
        #2;
        check("R9 read F word 3", ram_rdata, 1'b1);
        ram_addr = 5'h13;
        #2;
        check("R9 read G word 3", ram_rdata, 1'b1);
        ram_addr = 5'h04;
        #2;
        check("R9 unwritten word stays 0", ram_rdata, 1'b0);
        f_in = 4'h3; g_in = 4'h3;
        #2;
        check("R9 storage shared with F", f_out, 1'b1);
        check("R9 storage shared with G", g_out, 1'b1);

        // R10: restart clears completion and silences outputs
        restart();
        #2;
        check("R10 done low after restart", cfg_done, 1'b0);
        check("R10 f_out low after restart", f_out, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule